// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

This block is a 16-bit up-counter with one 8-bit control and status register. Software chooses one of two operating styles. In capture style, a falling edge on an external trigger pin stores the running count in a companion 16-bit register. In auto-reload style, the count is loaded from that same register when it wraps past its maximum. A falling trigger edge can also force the load. The counter advances either on a system clock-enable tick or on falling edges of an external count pin.

A baud mode is entered by setting either of the two serial-clock select bits. In this mode the counter always reloads when it wraps, and trigger-pin events are ignored. The overflow flag is never raised. Instead, each wrap produces a one-cycle pulse on the transmit tick output, the receive tick output, or both, for use by a serial port.

The two flags drive one interrupt request line. Software reads and writes the registers through a simple port with a write strobe and a combinational read.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, all five registers read 0x00, and `irq`, `tx_tick` and `rx_tick` are low.
- R2: The register port uses these addresses: 0 is control, 1 and 2 are the count low and high bytes, and 3 and 4 are the reload/capture low and high bytes. A write is readable at the next falling clock edge. The control bits are: 7 overflow flag, 6 trigger flag, 5 receive-tick select, 4 transmit-tick select, 3 trigger enable, 2 run, 1 count-source select, 0 capture select.
- R3: With run (bit 2) at 0, the count holds. With run at 1 and count-source select (bit 1) at 0, the count rises by one on each cycle in which `sys_tick` is high.
- R4: With count-source select at 1, the count rises by one for each falling edge on `cnt_pin`, three clock edges after the pin falls, and `sys_tick` is ignored.
- R5: With capture select (bit 0) at 0 and both tick selects at 0, a wrap from 0xFFFF loads the reload value into the count and sets the overflow flag.
- R6: With capture select at 1 and trigger enable (bit 3) at 1, a falling edge on `trig_pin` copies the count into the reload/capture register and sets the trigger flag. The count is left unchanged.
- R7: With capture select at 0 and trigger enable at 1, a falling edge on `trig_pin` loads the reload value into the count and sets the trigger flag.
- R8: With trigger enable at 0, a falling edge on `trig_pin` changes no register.
- R9: With either tick select (bit 5 or bit 4) at 1, a wrap always reloads the count, whatever the capture select. In this mode the overflow flag is not set, and trigger edges set no flag and cause no capture.
- R10: `tx_tick` pulses high for one cycle after a wrap when bit 4 is 1. `rx_tick` does the same when bit 5 is 1. Neither pulses when its select bit is 0.
- R11: `irq` is high exactly when the overflow flag or the trigger flag is 1. Each flag stays set until software writes 0 to it.
- R12: If a flag is set by hardware in the same cycle that software writes 0 to it, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sys_tick | input | 1 | Clock-enable tick for timer counting |
| cnt_pin | input | 1 | External count input (asynchronous) |
| trig_pin | input | 1 | External trigger input (asynchronous) |
| irq | output | 1 | Interrupt request |
| tx_tick | output | 1 | Transmit baud tick pulse |
| rx_tick | output | 1 | Receive baud tick pulse |

## Verification
The hardest case to reach is a hardware flag set landing on the same clock edge as a software write to the control register. The bench creates this by preloading the count to 0xFFFF with run set. It then raises `sys_tick` and the write strobe together for exactly one cycle, so the wrap and the clearing write coincide. Baud mode is also driven with capture select and trigger enable both set, and a trigger edge is applied. This shows that the mode overrides both the capture path and the trigger flag.

// File: rtl/crt_pkg.sv
// Package: shared constants and control-register layout for the
// capture/auto-reload timer. Assumes an 8-bit register port.
package crt_pkg;
    localparam int BYTE_W = 8;

    // Control register bit positions (software decodes these)
    localparam int B_OVF  = 7;
    localparam int B_EXT  = 6;
    localparam int B_RXS  = 5;
    localparam int B_TXS  = 4;
    localparam int B_TEN  = 3;
    localparam int B_RUN  = 2;
    localparam int B_SRC  = 1;
    localparam int B_CAP  = 0;

    typedef struct packed {
        logic ovf;      // overflow flag
        logic ext;      // trigger flag
        logic rx_sel;   // receive tick select
        logic tx_sel;   // transmit tick select
        logic trg_en;   // trigger enable
        logic run;      // run control
        logic src_pin;  // 1: count pin edges, 0: sys_tick
        logic cap_sel;  // 1: capture, 0: auto-reload
    } ctrl_t;
endpackage

// File: rtl/crt_fall_sync.sv
// Module: crt_fall_sync
// Synchronizes one asynchronous pin through STAGES flops and flags a
// falling edge by comparing the last synchronized sample with the one
// before. Assumes the pin idles high; the chain resets to all ones so
// no false edge appears after reset.
module crt_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] chain_q;

    // Shift the pin through the synchronizer and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], pin};
    end

    // Falling edge: previous sample high, current synchronized sample low
    always_comb fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/crt_count_core.sv
// Module: crt_count_core
// Holds the up-counter and the reload/capture register. A software
// byte write to the counter beats a reload or increment in the same
// cycle; a capture beats a software write to the reload register.
// Assumes the caller decides when reload and capture happen.
module crt_count_core #(
    parameter int CNT_W = 16,
    localparam int NB   = CNT_W / crt_pkg::BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc,
    input  logic                      do_reload,
    input  logic                      do_capture,
    input  logic [NB-1:0]             cnt_we,
    input  logic [NB-1:0]             rld_we,
    input  logic [crt_pkg::BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]          cnt_q,
    output logic [CNT_W-1:0]          rld_q,
    output logic                      wrap
);
    localparam int BW = crt_pkg::BYTE_W;

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] rld_nxt;

    // Wrap happens when an increment meets an all-ones count
    always_comb wrap = inc & (&cnt_q);

    // Counter next state: reload, else increment, then byte writes
    always_comb begin
        cnt_nxt = cnt_q;
        if (do_reload)  cnt_nxt = rld_q;
        else if (inc)   cnt_nxt = cnt_q + 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (cnt_we[i]) cnt_nxt[i*BW +: BW] = wdata;
        end
    end

    // Reload register next state: byte writes, then capture overrides
    always_comb begin
        rld_nxt = rld_q;
        for (int i = 0; i < NB; i++) begin
            if (rld_we[i]) rld_nxt[i*BW +: BW] = wdata;
        end
        if (do_capture) rld_nxt = cnt_q;
    end

    // Register both values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            rld_q <= rld_nxt;
        end
    end
endmodule

// File: rtl/crt_ctrl_reg.sv
// Module: crt_ctrl_reg
// Control/status register. Software writes load all eight bits; the
// two flag bits are then forced to 1 by a hardware set in the same
// cycle, so hardware wins over a clearing write.
module crt_ctrl_reg (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [crt_pkg::BYTE_W-1:0] wdata,
    input  logic                       ovf_set,
    input  logic                       ext_set,
    output crt_pkg::ctrl_t             ctrl_q
);
    // Load on write; hardware flag sets take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr)      ctrl_q     <= crt_pkg::ctrl_t'(wdata);
            if (ovf_set) ctrl_q.ovf <= 1'b1;
            if (ext_set) ctrl_q.ext <= 1'b1;
        end
    end
endmodule

// File: rtl/cap_reload_timer.sv
// Module: cap_reload_timer (top)
// 16-bit capture / auto-reload timer with baud tick outputs. Decodes
// the register port, synchronizes the pins, decides reload, capture
// and flag events and produces registered baud tick pulses.
// Assumes pins are asynchronous and idle high; reads are combinational.
module cap_reload_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int NB         = CNT_W / crt_pkg::BYTE_W,
    localparam int ADDR_W     = $clog2(2 * NB + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [crt_pkg::BYTE_W-1:0] reg_wdata,
    output logic [crt_pkg::BYTE_W-1:0] reg_rdata,
    input  logic                       sys_tick,
    input  logic                       cnt_pin,
    input  logic                       trig_pin,
    output logic                       irq,
    output logic                       tx_tick,
    output logic                       rx_tick
);
    import crt_pkg::*;

    localparam int BW = BYTE_W;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             wrap;
    logic [1:0]       pins;
    logic [1:0]       falls;
    logic             cnt_fall;
    logic             trig_fall;
    logic             baud;
    logic             inc;
    logic             rld_evt;
    logic             cap_evt;
    logic             ovf_set;
    logic             ext_set;
    logic             wr_ctrl;
    logic [NB-1:0]    cnt_we;
    logic [NB-1:0]    rld_we;
    logic             wr_cnt;

    // Pin vector: index 0 count pin, index 1 trigger pin
    always_comb pins = {trig_pin, cnt_pin};

    // One synchronizer and edge detector per external pin
    for (genvar p = 0; p < 2; p++) begin : g_pin
        crt_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[p]),
            .fall (falls[p])
        );
    end

    always_comb cnt_fall  = falls[0];
    always_comb trig_fall = falls[1];

    // Address decode for register writes
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(0));
        for (int i = 0; i < NB; i++) begin
            cnt_we[i] = reg_wr && (reg_addr == ADDR_W'(1 + i));
            rld_we[i] = reg_wr && (reg_addr == ADDR_W'(1 + NB + i));
        end
        wr_cnt = |cnt_we;
    end

    // Event decisions: increment source, reload, capture, flag sets
    always_comb begin
        baud    = ctrl_q.rx_sel | ctrl_q.tx_sel;
        inc     = ctrl_q.run & (ctrl_q.src_pin ? cnt_fall : sys_tick);
        rld_evt = (wrap & (baud | ~ctrl_q.cap_sel))
                | (~baud & ctrl_q.trg_en & ~ctrl_q.cap_sel & trig_fall);
        cap_evt = ~baud & ctrl_q.trg_en & ctrl_q.cap_sel & trig_fall;
        ovf_set = wrap & ~baud;
        ext_set = ~baud & ctrl_q.trg_en & trig_fall;
    end

    crt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .do_reload (rld_evt),
        .do_capture(cap_evt),
        .cnt_we    (cnt_we),
        .rld_we    (rld_we),
        .wdata     (reg_wdata),
        .cnt_q     (cnt_q),
        .rld_q     (rld_q),
        .wrap      (wrap)
    );

    crt_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .wdata  (reg_wdata),
        .ovf_set(ovf_set),
        .ext_set(ext_set),
        .ctrl_q (ctrl_q)
    );

    // Registered one-cycle baud tick pulses on each wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_tick <= 1'b0;
            rx_tick <= 1'b0;
        end else begin
            tx_tick <= wrap & ctrl_q.tx_sel;
            rx_tick <= wrap & ctrl_q.rx_sel;
        end
    end

    // Interrupt request from either flag
    always_comb irq = ctrl_q.ovf | ctrl_q.ext;

    // Combinational read mux over the register map
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(0)) reg_rdata = ctrl_q;
        for (int i = 0; i < NB; i++) begin
            if (reg_addr == ADDR_W'(1 + i))      reg_rdata = cnt_q[i*BW +: BW];
            if (reg_addr == ADDR_W'(1 + NB + i)) reg_rdata = rld_q[i*BW +: BW];
        end
    end
endmodule

// File: rtl/crt_checker.sv
// Module: crt_checker
// Assertion checker bound into cap_reload_timer. It only observes.
module crt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rld,
    input logic             wrap,
    input logic             rld_evt,
    input logic             cap_evt,
    input logic             wr_ctrl,
    input logic             wr_cnt,
    input logic             tx_tick,
    input logic             rx_tick
);
    import crt_pkg::*;

    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_RUN] && !wr_cnt && !rld_evt) |=> (cnt == $past(cnt)));

    p_reload_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_evt && !wr_cnt) |=> (cnt == $past(rld)));

    p_capture_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (rld == $past(cnt)));

    p_baud_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_OVF] && (ctrl[B_RXS] || ctrl[B_TXS]) && !wr_ctrl) |=> !ctrl[B_OVF]);

    p_tx_tick_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> ($past(ctrl[B_TXS]) && $past(wrap)));

    p_rx_tick_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> ($past(ctrl[B_RXS]) && $past(wrap)));

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[B_OVF] && !wr_ctrl) |=> ctrl[B_OVF]);

    p_ext_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[B_EXT] && !wr_ctrl) |=> ctrl[B_EXT]);

    p_hw_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wrap && !ctrl[B_RXS] && !ctrl[B_TXS]) |=> ctrl[B_OVF]);
endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl_q),
    .cnt    (cnt_q),
    .rld    (rld_q),
    .wrap   (wrap),
    .rld_evt(rld_evt),
    .cap_evt(cap_evt),
    .wr_ctrl(wr_ctrl),
    .wr_cnt (wr_cnt),
    .tx_tick(tx_tick),
    .rx_tick(rx_tick)
);

// File: tb/cap_reload_timer_bench.sv
// Directed bench for cap_reload_timer: one task per scenario.
module cap_reload_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_tick = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, tx_tick, rx_tick;

    int n_chk = 0;
    int n_bad = 0;
    int tx_seen = 0;
    int rx_seen = 0;

    always #5 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_tick(sys_tick),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    // Count tick pulses, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && tx_tick) tx_seen++;
        if (rst_n && rx_tick) rx_seen++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] d);
        wr(a, d[7:0]);
        wr(a + 3'd1, d[15:8]);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        sys_tick = 1'b1;
        repeat (n) @(negedge clk);
        sys_tick = 1'b0;
    endtask

    task automatic trig_fall_pulse();
        @(negedge clk);
        trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        trig_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 register reset", d, 0);
        end
        check("R1 irq reset", irq, 0);
        check("R1 ticks reset", {tx_tick, rx_tick}, 0);
    endtask

    task automatic t_regmap();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd1, 16'h1234);
        wr16(3'd3, 16'hABCD);
        wr(3'd0, 8'h0A);
        rd16(3'd1, v); check("R2 count bytes", v, 16'h1234);
        rd16(3'd3, v); check("R2 reload bytes", v, 16'hABCD);
        rd(3'd0, c);   check("R2 control readback", c, 8'h0A);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_timer();
        logic [15:0] v;
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h04);
        repeat (5) @(negedge clk);
        rd16(3'd1, v); check("R3 no tick no count", v, 0);
        ticks(7);
        rd16(3'd1, v); check("R3 count per tick", v, 7);
        wr(3'd0, 8'h00);
        ticks(6);
        rd16(3'd1, v); check("R3 stopped holds", v, 7);
    endtask

    task automatic t_pin_count();
        logic [15:0] v;
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h06);
        @(negedge clk); sys_tick = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cnt_pin = 1'b0; repeat (4) @(negedge clk);
            cnt_pin = 1'b1; repeat (4) @(negedge clk);
        end
        sys_tick = 1'b0;
        rd16(3'd1, v); check("R4 pin edge count", v, 5);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_auto_reload();
        logic [15:0] v; logic [7:0] c;
        tx_seen = 0; rx_seen = 0;
        wr16(3'd3, 16'h1234);
        wr16(3'd1, 16'hFFFD);
        wr(3'd0, 8'h04);
        ticks(3);
        rd16(3'd1, v); check("R5 reload on wrap", v, 16'h1234);
        rd(3'd0, c);   check("R5 overflow flag", c, 8'h84);
        check("R11 irq from overflow", irq, 1);
        check("R10 no ticks without select", tx_seen + rx_seen, 0);
        @(negedge clk);
        check("R11 flag sticky", irq, 1);
        wr(3'd0, 8'h00);
        check("R11 irq cleared", irq, 0);
    endtask

    task automatic t_capture();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd1, 16'h0100);
        wr16(3'd3, 16'h0000);
        wr(3'd0, 8'h0D);
        trig_fall_pulse();
        rd16(3'd3, v); check("R6 captured value", v, 16'h0100);
        rd16(3'd1, v); check("R6 count unchanged", v, 16'h0100);
        rd(3'd0, c);   check("R6 trigger flag", c, 8'h4D);
        check("R11 irq from trigger flag", irq, 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_reload();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd3, 16'h5555);
        wr16(3'd1, 16'h0010);
        wr(3'd0, 8'h0C);
        trig_fall_pulse();
        rd16(3'd1, v); check("R7 trigger reload", v, 16'h5555);
        rd(3'd0, c);   check("R7 trigger flag", c, 8'h4C);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_disabled();
        logic [15:0] v; logic [7:0] c;
        wr16(3'd3, 16'h7777);
        wr16(3'd1, 16'h0020);
        wr(3'd0, 8'h05);
        trig_fall_pulse();
        rd16(3'd1, v); check("R8 count untouched", v, 16'h0020);
        rd16(3'd3, v); check("R8 reload untouched", v, 16'h7777);
        rd(3'd0, c);   check("R8 no flag", c, 8'h05);
        check("R8 irq low", irq, 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_baud();
        logic [15:0] v; logic [7:0] c;
        tx_seen = 0; rx_seen = 0;
        wr16(3'd3, 16'hFFF0);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, 8'h1D);
        ticks(2);
        rd16(3'd1, v); check("R9 baud forces reload", v, 16'hFFF0);
        rd(3'd0, c);   check("R9 no overflow flag", c, 8'h1D);
        check("R10 tx tick once", tx_seen, 1);
        check("R10 rx tick none", rx_seen, 0);
        trig_fall_pulse();
        rd16(3'd3, v); check("R9 no capture in baud", v, 16'hFFF0);
        rd(3'd0, c);   check("R9 no trigger flag", c, 8'h1D);
        tx_seen = 0; rx_seen = 0;
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h24);
        ticks(1);
        repeat (2) @(negedge clk);
        check("R10 rx tick once", rx_seen, 1);
        check("R10 tx tick none", tx_seen, 0);
        tx_seen = 0; rx_seen = 0;
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h34);
        ticks(1);
        repeat (2) @(negedge clk);
        check("R10 both ticks", tx_seen * 16 + rx_seen, 16'h11);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_hw_wins();
        logic [7:0] c;
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h04);
        @(negedge clk);
        sys_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h04;
        @(negedge clk);
        sys_tick = 1'b0; reg_wr = 1'b0;
        rd(3'd0, c); check("R12 hardware set wins", c, 8'h84);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_timer();
        t_pin_count();
        t_auto_reload();
        t_capture();
        t_trig_reload();
        t_trig_disabled();
        t_baud();
        t_hw_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule